// File: doc/BRIEF.md
# SDRAM Bank Protocol Model

This block is a cycle-accurate, synthesizable model of a single SDRAM bank that listens to the RAS/CAS/WE command bus. It tracks the bank through four phases: idle (bitlines precharged), sensing (row activated but not yet usable), open (row held in the sense-amplifier page), and restoring (precharge in progress). It keeps its cells in a small array. It holds the whole activated page in a row buffer until precharge writes the page back. It returns read words after a fixed CAS latency.

The model is meant to sit next to a command sequencer in a self-checking testbench, or on an FPGA prototype. Its job there is to catch protocol mistakes. A command that arrives while the bank cannot accept it is refused and has no effect. The first such violation is latched into a sticky flag with a 3-bit cause code, which is held until reset. Refresh, electrical behaviour and multiple banks are outside the model.

Top module: `sdram_bank_model`

## Requirements
- R1: After a synchronous active-low reset, `rvalid`, `err` and `err_code` are 0, the bank is idle, and every stored word reads as 0.
- R2: Commands are decoded from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge. Activate from idle loads the row given by `addr[ROW_W-1:0]`. Column commands become legal TRCD clock edges after the activate edge.
- R3: A write in an open row stores `wdata` at column `addr[COL_W-1:0]` of the page. A later read of that column in the same open row returns the last value written.
- R4: For a read accepted at edge t, `rdata` and `rvalid` are updated at edge t+CL-1 and hold for one cycle, so they are consumed at edge t+CL. Back-to-back reads return their words in command order.
- R5: Precharge writes the whole page back to the array. Data survives closing and reopening the row, and a row is never altered by activity on another row.
- R6: Precharge keeps the bank busy for TRP edges. An activate arriving earlier than that sets error code 1; an activate arriving exactly then is accepted.
- R7: A read or write arriving during the sensing window (fewer than TRCD edges after activate) sets error code 2.
- R8: A read or write while no row is open (idle or restoring) sets error code 3.
- R9: An activate while a row is sensing or open sets error code 4.
- R10: A precharge during the sensing window sets error code 5. A precharge while idle or already restoring is ignored without error.
- R11: A refused command changes neither the bank phase, the page nor the array, and a refused read produces no `rvalid`.
- R12: The first violation sets `err` and its code. Both hold until reset, and later violations leave the code unchanged; `err` is 1 exactly when `err_code` is non-zero.
- R13: The encodings 111, 000, 001 and 110 have no effect on the bank or the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | max(ROW_W,COL_W) | Row address on activate, column address on read/write |
| wdata | input | DATA_W | Data for a write command |
| rdata | output | DATA_W | Read word, valid while `rvalid` is high |
| rvalid | output | 1 | Read data valid strobe |
| err | output | 1 | Sticky protocol-violation flag |
| err_code | output | 3 | Cause of the first violation (0 when none) |

## Verification
The bench builds the model at its defaults: 8 rows of 4 words of 8 bits, TRCD=2, TRP=2 and CL=2. With this geometry every word of every row can be written, closed, reopened and read back. It also lets each timing window be swept one edge at a time on both sides of its limit. Each violation class is then provoked from a fresh reset, and the bank is afterwards driven legally to show at the ports that the refused command left the page and array untouched.

// File: rtl/sdram_bank_pkg.sv
// Shared types for the SDRAM bank model.
// Assumes command strobes are active low and sampled on the rising clock edge.
package sdram_bank_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_SENSE   = 2'd1,
        BK_OPEN    = 2'd2,
        BK_RESTORE = 2'd3
    } bank_state_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } bank_cmd_e;

    localparam logic [2:0] ERR_NONE         = 3'd0;
    localparam logic [2:0] ERR_ACT_IN_PRE   = 3'd1;
    localparam logic [2:0] ERR_COL_IN_SENSE = 3'd2;
    localparam logic [2:0] ERR_COL_CLOSED   = 3'd3;
    localparam logic [2:0] ERR_ACT_ON_OPEN  = 3'd4;
    localparam logic [2:0] ERR_PRE_IN_SENSE = 3'd5;

    // Map the three strobes to a command; unlisted encodings act as no-ops.
    function automatic bank_cmd_e decode_cmd(input logic ras_n, input logic cas_n, input logic we_n);
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_READ;
            3'b100:  return CMD_WRITE;
            3'b010:  return CMD_PRE;
            default: return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/bank_fsm.sv
// Bank phase tracker: decides which commands are legal in the current phase,
// emits one-cycle accept strobes, and reports a cause code for refused ones.
// Assumes TRCD >= 1 and TRP >= 1 (counted in clock edges).
module bank_fsm
    import sdram_bank_pkg::*;
#(
    parameter int TRCD = 2,
    parameter int TRP  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  bank_cmd_e   cmd,
    output bank_state_e state_o,
    output logic        do_act,
    output logic        do_rd,
    output logic        do_wr,
    output logic        do_pre,
    output logic [2:0]  viol
);

    localparam int MAXD  = (TRCD > TRP) ? TRCD : TRP;
    localparam int CNT_W = $clog2(MAXD + 1);

    bank_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    assign state_o = state_q;

    // Legality table: accept or refuse the incoming command in this phase.
    always_comb begin
        do_act = 1'b0;
        do_rd  = 1'b0;
        do_wr  = 1'b0;
        do_pre = 1'b0;
        viol   = ERR_NONE;
        case (cmd)
            CMD_ACT: begin
                case (state_q)
                    BK_IDLE:    do_act = 1'b1;
                    BK_RESTORE: viol   = ERR_ACT_IN_PRE;
                    default:    viol   = ERR_ACT_ON_OPEN;
                endcase
            end
            CMD_READ, CMD_WRITE: begin
                case (state_q)
                    BK_OPEN: begin
                        do_rd = (cmd == CMD_READ);
                        do_wr = (cmd == CMD_WRITE);
                    end
                    BK_SENSE: viol = ERR_COL_IN_SENSE;
                    default:  viol = ERR_COL_CLOSED;
                endcase
            end
            CMD_PRE: begin
                case (state_q)
                    BK_OPEN:  do_pre = 1'b1;
                    BK_SENSE: viol   = ERR_PRE_IN_SENSE;
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

    // Phase register with the sensing and restore countdowns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                BK_IDLE: begin
                    if (do_act) begin
                        if (TRCD > 1) begin
                            state_q <= BK_SENSE;
                            cnt_q   <= CNT_W'(TRCD - 1);
                        end else begin
                            state_q <= BK_OPEN;
                        end
                    end
                end
                BK_SENSE: begin
                    if (cnt_q == CNT_W'(1)) state_q <= BK_OPEN;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                BK_OPEN: begin
                    if (do_pre) begin
                        if (TRP > 1) begin
                            state_q <= BK_RESTORE;
                            cnt_q   <= CNT_W'(TRP - 1);
                        end else begin
                            state_q <= BK_IDLE;
                        end
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(1)) state_q <= BK_IDLE;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/row_store.sv
// Cell array plus the page (row) buffer. Activate copies a row into the page,
// writes update the page only, and precharge copies the page back to its row.
// Assumes the accept strobes are mutually exclusive in any one cycle.
module row_store #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic              do_wr,
    input  logic              do_pre,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [COLS-1:0][DATA_W-1:0] cells_q [ROWS];
    logic [COLS-1:0][DATA_W-1:0] page_q;
    logic [ROW_W-1:0]            open_row_q;

    assign rd_word = page_q[col_addr];

    // Array and page update: load on activate, modify on write, restore on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
            page_q     <= '0;
            open_row_q <= '0;
        end else begin
            if (do_act) begin
                page_q     <= cells_q[row_addr];
                open_row_q <= row_addr;
            end
            if (do_wr) page_q[col_addr] <= wdata;
            if (do_pre) cells_q[open_row_q] <= page_q;
        end
    end

endmodule

// File: rtl/read_pipe.sv
// CAS-latency delay line: a read word enters at the accept edge and leaves
// CL-1 edges later. Assumes CL >= 1.
module read_pipe #(
    parameter int CL     = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);

    logic              vld_q [CL];
    logic [DATA_W-1:0] dat_q [CL];

    // First stage: capture the page word of an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            dat_q[0] <= in_vld ? in_data : '0;
        end
    end

    for (genvar i = 1; i < CL; i++) begin : g_stage
        // Later stages: shift the word one edge further toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                dat_q[i] <= '0;
            end else begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    assign out_vld  = vld_q[CL-1];
    assign out_data = dat_q[CL-1];

endmodule

// File: rtl/sdram_bank_model.sv
// Top of the single-bank SDRAM protocol model. Decodes the command bus,
// drives the phase tracker, page/array store and read delay line, and latches
// the first protocol violation. Assumes one command per clock edge.
module sdram_bank_model
    import sdram_bank_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8,
    parameter int TRCD   = 2,
    parameter int TRP    = 2,
    parameter int CL     = 2,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              err,
    output logic [2:0]        err_code
);

    bank_cmd_e         cmd;
    bank_state_e       bank_state;
    logic              do_act, do_rd, do_wr, do_pre;
    logic [2:0]        viol;
    logic [DATA_W-1:0] rd_word;
    logic              err_q;
    logic [2:0]        code_q;

    assign cmd = decode_cmd(ras_n, cas_n, we_n);

    bank_fsm #(.TRCD(TRCD), .TRP(TRP)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .state_o (bank_state),
        .do_act  (do_act),
        .do_rd   (do_rd),
        .do_wr   (do_wr),
        .do_pre  (do_pre),
        .viol    (viol)
    );

    row_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_act   (do_act),
        .do_wr    (do_wr),
        .do_pre   (do_pre),
        .row_addr (addr[ROW_W-1:0]),
        .col_addr (addr[COL_W-1:0]),
        .wdata    (wdata),
        .rd_word  (rd_word)
    );

    read_pipe #(.CL(CL), .DATA_W(DATA_W)) u_rpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (do_rd),
        .in_data  (rd_word),
        .out_vld  (rvalid),
        .out_data (rdata)
    );

    // Sticky capture of the first violation cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else if (!err_q && viol != ERR_NONE) begin
            err_q  <= 1'b1;
            code_q <= viol;
        end
    end

    assign err      = err_q;
    assign err_code = code_q;

endmodule

// File: rtl/sdram_bank_model_chk.sv
// Protocol checker for sdram_bank_model, attached by bind.
// Relates the command-bus ports, the bank phase and the error outputs over time.
module sdram_bank_model_chk
    import sdram_bank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input bank_state_e state,
    input logic        err,
    input logic [2:0]  err_code
);

    logic act_cmd, col_cmd;
    assign act_cmd = !ras_n && cas_n && we_n;
    assign col_cmd = ras_n && !cas_n;

    // R12: flag and cause stay put once set
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_code)));

    // R12: flag raised exactly when a cause is recorded
    a_r12_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        err == (err_code != 3'd0));

    // R2: activate from idle leaves idle
    a_r2_act_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_IDLE && act_cmd) |=> (state == BK_SENSE || state == BK_OPEN));

    // R6: restore only ends in idle
    a_r6_restore_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_RESTORE) |=> (state == BK_RESTORE || state == BK_IDLE));

    // R7: a column command in the sensing window records cause 2
    a_r7_col_in_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_SENSE && col_cmd && !err) |=> (err && err_code == 3'd2));

    // R9: activate on an open row records cause 4
    a_r9_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_OPEN && act_cmd && !err) |=> (err_code == 3'd4));

    // R11: an open row never goes back to sensing without precharge
    a_r11_open_no_resense: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_OPEN) |=> (state != BK_SENSE));

endmodule

bind sdram_bank_model sdram_bank_model_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .state    (bank_state),
    .err      (err),
    .err_code (err_code)
);

// File: tb/test_sdram_bank_model.sv
// Self-checking bench: full data sweep plus edge-by-edge timing-window sweeps.
module test_sdram_bank_model;

    localparam int ROW_W  = 3;
    localparam int COL_W  = 2;
    localparam int DATA_W = 8;
    localparam int TRCD   = 2;
    localparam int TRP    = 2;
    localparam int CL     = 2;
    localparam int ADDR_W = 3;

    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_PRE = 3'b010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;
    logic              err;
    logic [2:0]        err_code;

    int n_chk  = 0;
    int n_fail = 0;

    sdram_bank_model #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .TRCD(TRCD), .TRP(TRP), .CL(CL)
    ) i_sdram_bank_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .err(err), .err_code(err_code)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one command for one edge, return at the following negedge with NOP.
    task automatic drive(input logic [2:0] c, input int a, input int d);
        {ras_n, cas_n, we_n} = c;
        addr  = ADDR_W'(a);
        wdata = DATA_W'(d);
        @(posedge clk);
        @(negedge clk);
        {ras_n, cas_n, we_n} = C_NOP;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) drive(C_NOP, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_cycles(2);
        rst_n = 1'b1;
    endtask

    function automatic int pat(input int r, input int c);
        return (r * 37 + c * 11 + 5) & 8'hFF;
    endfunction

    // Legal read; check the word in the CL-1 slot after the command edge.
    task automatic read_expect(input int col, input int exp, input string tag);
        drive(C_RD, col, 0);
        idle_cycles(CL - 1);
        check(rvalid === 1'b1, {tag, " rvalid"}, int'(rvalid), 1);
        check(rdata === DATA_W'(exp), {tag, " rdata"}, int'(rdata), exp);
    endtask

    task automatic open_row(input int r);
        drive(C_ACT, r, 0);
        idle_cycles(TRCD - 1);
    endtask

    task automatic close_row();
        drive(C_PRE, 0, 0);
        idle_cycles(TRP - 1);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_up();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state at the ports
        check(rvalid === 1'b0, "R1 rvalid", int'(rvalid), 0);
        check(err === 1'b0, "R1 err", int'(err), 0);
        check(err_code === 3'd0, "R1 err_code", int'(err_code), 0);
        open_row(0);
        for (int c = 0; c < 4; c++) read_expect(c, 0, "R1 cleared word");
        close_row();

        // R2 R3: write every word of every row, read back while open
        for (int r = 0; r < 8; r++) begin
            open_row(r);
            for (int c = 0; c < 4; c++) drive(C_WR, c, pat(r, c) ^ 8'hFF);
            for (int c = 0; c < 4; c++) drive(C_WR, c, pat(r, c));
            for (int c = 0; c < 4; c++) read_expect(c, pat(r, c), "R3 open-row read");
            close_row();
        end
        // R5: reopen every row, data restored by precharge and not disturbed
        for (int r = 0; r < 8; r++) begin
            open_row(r);
            for (int c = 0; c < 4; c++) read_expect(c, pat(r, c), "R5 reopened read");
            close_row();
        end
        check(err === 1'b0, "R2 legal sweep no error", int'(err), 0);

        // R4: latency edge and back-to-back order
        open_row(2);
        drive(C_RD, 0, 0);
        check(rvalid === 1'b0, "R4 not before latency", int'(rvalid), 0);
        drive(C_RD, 1, 0);
        check(rvalid === 1'b1 && rdata === DATA_W'(pat(2, 0)), "R4 first of pair",
              int'(rdata), pat(2, 0));
        idle_cycles(1);
        check(rvalid === 1'b1 && rdata === DATA_W'(pat(2, 1)), "R4 second of pair",
              int'(rdata), pat(2, 1));
        idle_cycles(1);
        check(rvalid === 1'b0, "R4 single-cycle strobe", int'(rvalid), 0);
        close_row();

        // R7 R11: column command at each distance after activate
        for (int d = 1; d <= 3; d++) begin
            do_reset();
            drive(C_ACT, 2, 0);
            idle_cycles(d - 1);
            drive(C_RD, 1, 0);
            idle_cycles(CL - 1);
            if (d < TRCD) begin
                check(err === 1'b1 && err_code === 3'd2, "R7 column in sensing",
                      int'(err_code), 2);
                check(rvalid === 1'b0, "R11 refused read gives no data", int'(rvalid), 0);
            end else begin
                check(err === 1'b0, "R2 column after TRCD", int'(err), 0);
                check(rvalid === 1'b1, "R2 column after TRCD data", int'(rvalid), 1);
            end
        end

        // R6: activate at each distance after precharge
        for (int d = 1; d <= 3; d++) begin
            do_reset();
            open_row(0);
            drive(C_PRE, 0, 0);
            idle_cycles(d - 1);
            drive(C_ACT, 0, 0);
            if (d < TRP)
                check(err === 1'b1 && err_code === 3'd1, "R6 activate during restore",
                      int'(err_code), 1);
            else
                check(err === 1'b0, "R6 activate after TRP", int'(err), 0);
        end

        // R8 R11: write while idle is refused and leaves the row untouched
        do_reset();
        drive(C_WR, 0, 8'hAA);
        check(err_code === 3'd3, "R8 write while idle", int'(err_code), 3);
        open_row(0);
        read_expect(0, 0, "R11 idle write had no effect");
        close_row();

        // R8 R5: read during restore refused; write-back still happened
        do_reset();
        open_row(1);
        drive(C_WR, 2, 8'h55);
        drive(C_PRE, 0, 0);
        drive(C_RD, 2, 0);
        check(err_code === 3'd3, "R8 read during restore", int'(err_code), 3);
        idle_cycles(1);
        open_row(1);
        read_expect(2, 8'h55, "R5 write-back before refused read");
        close_row();

        // R9 R11 R12: activate on open row refused, later violation ignored
        do_reset();
        open_row(3);
        drive(C_WR, 0, 8'h11);
        drive(C_ACT, 4, 0);
        check(err_code === 3'd4, "R9 activate on open row", int'(err_code), 4);
        read_expect(0, 8'h11, "R11 page kept after refused activate");
        drive(C_PRE, 0, 0);
        drive(C_RD, 0, 0);
        check(err === 1'b1 && err_code === 3'd4, "R12 first cause held", int'(err_code), 4);
        idle_cycles(1);
        open_row(4);
        read_expect(0, 0, "R11 other row untouched");
        close_row();

        // R10 R11: precharge during sensing refused, row still opens
        do_reset();
        drive(C_ACT, 5, 0);
        drive(C_PRE, 0, 0);
        check(err_code === 3'd5, "R10 precharge in sensing", int'(err_code), 5);
        drive(C_WR, 1, 8'h22);
        read_expect(1, 8'h22, "R11 row stayed open");
        close_row();

        // R10: precharge while idle or restoring is harmless
        do_reset();
        drive(C_PRE, 0, 0);
        check(err === 1'b0, "R10 precharge while idle", int'(err), 0);
        open_row(6);
        drive(C_PRE, 0, 0);
        drive(C_PRE, 0, 0);
        check(err === 1'b0, "R10 precharge while restoring", int'(err), 0);

        // R13: spare encodings do nothing
        do_reset();
        open_row(6);
        drive(C_WR, 3, 8'h77);
        drive(3'b000, 3, 8'h01);
        drive(3'b001, 3, 8'h02);
        drive(3'b110, 3, 8'h03);
        check(err === 1'b0, "R13 spare encodings no error", int'(err), 0);
        read_expect(3, 8'h77, "R13 spare encodings no data change");
        close_row();

        finish_up();
    end

endmodule